// File: doc/BRIEF.md
# Page Request Queue Writer

This block takes page-request messages raised by devices and appends each one as a 16-byte descriptor to a circular queue that lives in system memory. Before it writes anything, it screens the request. The request is turned away if no process-address-space identifier comes with it, if it asks for execute access without read access, or if the device context does not enable page requests; the last of these is also flagged as a fault. When the queue has already overflowed, the request is dropped without any side effect. When the queue is full, the block marks the overflow and notifies the event-control block.

Once a descriptor has been written, the block hands the advanced tail offset back to the register file. It then sets the pending-request status if that status was clear. Every status change goes out as a one-cycle strobe, together with the status value that was sampled before the change, so that a separate event-control block can decide whether to raise an interrupt. Only one request is handled at a time, and the request interface stalls until the memory write response comes back.

Top module: `prq_writer`

## Requirements
- R1: After reset, `req_ready` is 1 and `mw_valid`, `rsp_valid`, `tail_we`, `set_ovf`, `set_pend`, `evt_req` and `fault` are all 0.
- R2: A request with `req_pasid_vld`=0 is answered with code 1 and causes no memory write. This check takes precedence over every other check.
- R3: A request with a PASID that has `req_exec`=1 and `req_rd`=0 is answered with code 2 and causes no memory write.
- R4: An otherwise valid request while `ctx_pr_en`=0 is answered with code 3, with `fault` pulsed together with `rsp_valid`. No memory write takes place.
- R5: An otherwise valid request while `st_ovf`=1 is answered with code 4. It causes no memory write, no `set_ovf`, no `evt_req` and no `fault`. This holds even when the queue is full.
- R6: When (tail + 32) mod 2^(q_size+12) equals `q_head`, the request is answered with code 5. In that case `set_ovf` and `evt_req` pulse, `evt_old` = {st_pend, st_ovf} as sampled at acceptance, and no write takes place.
- R7: An accepted request writes to address {q_base, 12'h000} + q_tail, where the offset is aligned to 32 bytes.
- R8: The descriptor on `mw_data` is laid out as follows. The low 64 bits hold [7:0]=8'h01, [9]=1 (PASID present), [31:16]=requester ID, [51:32]=PASID and [53]=privilege. The high 64 bits (mw_data[127:64]) hold [0]=read, [1]=write, [2]=last-in-group, [11:3]=group index and [63:12]=page address. All other bits are 0.
- R9: A write response without error gives code 0 and pulses `tail_we`, with `tail_nxt` = (q_tail + 32) mod 2^(q_size+12).
- R10: On a successful response with `st_pend`=0, `set_pend` and `evt_req` pulse with `evt_old` = {st_pend, st_ovf}. With `st_pend`=1, neither pulses.
- R11: A write response with `mw_resp_err`=1 gives code 6, with no `tail_we`, no `set_pend` and no `evt_req`.
- R12: From acceptance until the response pulse, `req_ready` is 0. `mw_valid` stays high with a stable address until `mw_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Page request present |
| req_ready | output | 1 | Block can accept a request |
| req_rid | input | 16 | Requester ID |
| req_pasid_vld | input | 1 | PASID accompanies request |
| req_pasid | input | 20 | PASID value |
| req_priv | input | 1 | Privileged-mode request |
| req_exec | input | 1 | Execute access requested |
| req_rd | input | 1 | Read access requested |
| req_wr | input | 1 | Write access requested |
| req_last | input | 1 | Last request of its group |
| req_grp | input | 9 | Page request group index |
| req_page | input | 52 | Page address bits 63:12 |
| ctx_pr_en | input | 1 | Device context enables page requests |
| q_base | input | ADDR_W-12 | Queue base address, 4 KiB aligned |
| q_size | input | 3 | Queue holds 2^(q_size+7) entries |
| q_head | input | OFF_W | Head byte offset |
| q_tail | input | OFF_W | Tail byte offset |
| tail_we | output | 1 | Tail update strobe |
| tail_nxt | output | OFF_W | New tail byte offset |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory accepts write |
| mw_addr | output | ADDR_W | Write byte address |
| mw_data | output | 128 | Descriptor |
| mw_resp_valid | input | 1 | Write response |
| mw_resp_err | input | 1 | Write response carries an error |
| st_ovf | input | 1 | Queue overflow status |
| st_pend | input | 1 | Pending request status |
| set_ovf | output | 1 | Set overflow status strobe |
| set_pend | output | 1 | Set pending status strobe |
| evt_req | output | 1 | Evaluate event strobe |
| evt_old | output | 2 | Status before change {pend, ovf} |
| rsp_valid | output | 1 | Result strobe |
| rsp_code | output | 3 | Result code (0..6) |
| fault | output | 1 | Fault report strobe |

## Verification
The assertions take for granted that `mw_resp_valid` arrives only after the block's write has been taken, and that the status, queue and context inputs stay steady from acceptance until the result. The stimulus respects both conditions. It raises a response only after it has seen `mw_valid` and an accepting edge. It holds every queue and status input constant for the whole life of each request, and it changes them only between requests, after the result strobe has been sampled.

// File: rtl/prq_pkg.sv
package prq_pkg;
    localparam int RID_W    = 16;
    localparam int PASID_W  = 20;
    localparam int GRP_W    = 9;
    localparam int PAGE_W   = 52;
    localparam int DESC_W   = 128;
    localparam int ENTRY_LG = 5;   // 32-byte slots
    localparam int SIZE_LG0 = 7;   // entries = 2^(size+7)
    localparam logic [7:0] DESC_TYPE = 8'h01;

    typedef enum logic [2:0] {
        RSP_OK       = 3'd0,
        RSP_NO_PASID = 3'd1,
        RSP_BAD_EXEC = 3'd2,
        RSP_DISABLED = 3'd3,
        RSP_DROPPED  = 3'd4,
        RSP_FULL     = 3'd5,
        RSP_IO_ERR   = 3'd6
    } prq_rsp_e;

    typedef enum logic [1:0] {S_IDLE, S_WRITE, S_WAIT, S_DONE} prq_state_e;

    typedef struct packed {
        logic [RID_W-1:0]   rid;
        logic               pasid_vld;
        logic [PASID_W-1:0] pasid;
        logic               priv;
        logic               exec;
        logic               rd;
        logic               wr;
        logic               last;
        logic [GRP_W-1:0]   grp;
        logic [PAGE_W-1:0]  page;
    } prq_req_t;

    typedef struct packed {
        logic [63:0] hi;
        logic [63:0] lo;
    } prq_desc_t;
endpackage

// File: rtl/prq_screen.sv
module prq_screen
    import prq_pkg::*;
(
    input  prq_req_t req,
    input  logic     pr_en,
    input  logic     ovf,
    input  logic     full,
    output prq_rsp_e verdict,
    output logic     is_fault
);
    always_comb begin
        is_fault = 1'b0;
        if (!req.pasid_vld) begin
            verdict = RSP_NO_PASID;
        end else if (req.exec && !req.rd) begin
            verdict = RSP_BAD_EXEC;
        end else if (!pr_en) begin
            verdict  = RSP_DISABLED;
            is_fault = 1'b1;
        end else if (ovf) begin
            verdict = RSP_DROPPED;
        end else if (full) begin
            verdict = RSP_FULL;
        end else begin
            verdict = RSP_OK;
        end
    end
endmodule

// File: rtl/prq_ring.sv
module prq_ring
    import prq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 19
) (
    input  logic [ADDR_W-13:0] base,
    input  logic [2:0]         size,
    input  logic [OFF_W-1:0]   head,
    input  logic [OFF_W-1:0]   tail,
    output logic [OFF_W-1:0]   tail_next,
    output logic               full,
    output logic [ADDR_W-1:0]  slot_addr
);
    localparam logic [OFF_W-1:0] ALIGN = ~OFF_W'((1 << ENTRY_LG) - 1);
    localparam logic [OFF_W-1:0] STEP  = OFF_W'(1 << ENTRY_LG);

    logic [OFF_W:0]   span;
    logic [OFF_W-1:0] wrap_mask;
    logic [OFF_W-1:0] head_al;
    logic [OFF_W-1:0] tail_al;

    always_comb begin
        span      = (OFF_W+1)'(1) << (int'(size) + ENTRY_LG + SIZE_LG0);
        wrap_mask = OFF_W'(span - (OFF_W+1)'(1));
        head_al   = head & ALIGN;
        tail_al   = tail & ALIGN;
        tail_next = (tail_al + STEP) & wrap_mask;
        full      = (tail_next == head_al);
        slot_addr = {base, 12'h000} + ADDR_W'(tail_al);
    end
endmodule

// File: rtl/prq_pack.sv
module prq_pack
    import prq_pkg::*;
(
    input  prq_req_t  req,
    output prq_desc_t desc
);
    always_comb begin
        desc          = '0;
        desc.lo[7:0]  = DESC_TYPE;
        desc.lo[9]    = 1'b1;
        desc.lo[31:16] = req.rid;
        desc.lo[51:32] = req.pasid;
        desc.lo[53]   = req.priv;
        desc.hi[0]    = req.rd;
        desc.hi[1]    = req.wr;
        desc.hi[2]    = req.last;
        desc.hi[11:3] = req.grp;
        desc.hi[63:12] = req.page;
    end
endmodule

// File: rtl/prq_writer.sv
module prq_writer
    import prq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [RID_W-1:0]    req_rid,
    input  logic                req_pasid_vld,
    input  logic [PASID_W-1:0]  req_pasid,
    input  logic                req_priv,
    input  logic                req_exec,
    input  logic                req_rd,
    input  logic                req_wr,
    input  logic                req_last,
    input  logic [GRP_W-1:0]    req_grp,
    input  logic [PAGE_W-1:0]   req_page,
    input  logic                ctx_pr_en,
    input  logic [ADDR_W-13:0]  q_base,
    input  logic [2:0]          q_size,
    input  logic [OFF_W-1:0]    q_head,
    input  logic [OFF_W-1:0]    q_tail,
    output logic                tail_we,
    output logic [OFF_W-1:0]    tail_nxt,
    output logic                mw_valid,
    input  logic                mw_ready,
    output logic [ADDR_W-1:0]   mw_addr,
    output logic [DESC_W-1:0]   mw_data,
    input  logic                mw_resp_valid,
    input  logic                mw_resp_err,
    input  logic                st_ovf,
    input  logic                st_pend,
    output logic                set_ovf,
    output logic                set_pend,
    output logic                evt_req,
    output logic [1:0]          evt_old,
    output logic                rsp_valid,
    output logic [2:0]          rsp_code,
    output logic                fault
);
    prq_state_e       state;
    prq_req_t         req_in;
    prq_desc_t        desc;
    prq_rsp_e         verdict;
    logic             chk_fault;
    logic             ring_full;
    logic [OFF_W-1:0] ring_next;
    logic [ADDR_W-1:0] ring_addr;

    assign req_in = '{rid: req_rid, pasid_vld: req_pasid_vld, pasid: req_pasid,
                      priv: req_priv, exec: req_exec, rd: req_rd, wr: req_wr,
                      last: req_last, grp: req_grp, page: req_page};

    prq_screen u_screen (
        .req      (req_in),
        .pr_en    (ctx_pr_en),
        .ovf      (st_ovf),
        .full     (ring_full),
        .verdict  (verdict),
        .is_fault (chk_fault)
    );

    prq_ring #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ring (
        .base      (q_base),
        .size      (q_size),
        .head      (q_head),
        .tail      (q_tail),
        .tail_next (ring_next),
        .full      (ring_full),
        .slot_addr (ring_addr)
    );

    prq_pack u_pack (
        .req  (req_in),
        .desc (desc)
    );

    assign req_ready = (state == S_IDLE);
    assign mw_valid  = (state == S_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            mw_addr   <= '0;
            mw_data   <= '0;
            tail_nxt  <= '0;
            tail_we   <= 1'b0;
            set_ovf   <= 1'b0;
            set_pend  <= 1'b0;
            evt_req   <= 1'b0;
            evt_old   <= 2'b00;
            rsp_valid <= 1'b0;
            rsp_code  <= 3'd0;
            fault     <= 1'b0;
        end else begin
            tail_we   <= 1'b0;
            set_ovf   <= 1'b0;
            set_pend  <= 1'b0;
            evt_req   <= 1'b0;
            evt_old   <= 2'b00;
            rsp_valid <= 1'b0;
            fault     <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        if (verdict == RSP_OK) begin
                            mw_addr  <= ring_addr;
                            mw_data  <= desc;
                            tail_nxt <= ring_next;
                            state    <= S_WRITE;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_code  <= verdict;
                            fault     <= chk_fault;
                            if (verdict == RSP_FULL) begin
                                set_ovf <= 1'b1;
                                evt_req <= 1'b1;
                                evt_old <= {st_pend, st_ovf};
                            end
                            state <= S_DONE;
                        end
                    end
                end
                S_WRITE: begin
                    if (mw_ready) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (mw_resp_valid) begin
                        rsp_valid <= 1'b1;
                        state     <= S_DONE;
                        if (mw_resp_err) begin
                            rsp_code <= RSP_IO_ERR;
                        end else begin
                            rsp_code <= RSP_OK;
                            tail_we  <= 1'b1;
                            if (!st_pend) begin
                                set_pend <= 1'b1;
                                evt_req  <= 1'b1;
                                evt_old  <= {st_pend, st_ovf};
                            end
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prq_writer_sva.sv
module prq_writer_sva #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mw_valid,
    input logic              mw_ready,
    input logic [ADDR_W-1:0] mw_addr,
    input logic              rsp_valid,
    input logic [2:0]        rsp_code,
    input logic              fault,
    input logic              tail_we,
    input logic              set_ovf,
    input logic              set_pend,
    input logic              evt_req
);
    AST_WRITE_BLOCKS_INTAKE: assert property (@(posedge clk) disable iff (rst)
        mw_valid |-> !req_ready); // R12
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr)); // R12
    AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mw_valid |-> mw_addr[4:0] == 5'd0); // R7
    AST_FAULT_ONLY_DISABLED: assert property (@(posedge clk) disable iff (rst)
        fault |-> rsp_valid && rsp_code == 3'd3); // R4
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == 3'd4 |-> !set_ovf && !evt_req && !fault); // R5
    AST_FULL_MARKS_OVF: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == 3'd5 |-> set_ovf && evt_req && !tail_we); // R6
    AST_TAIL_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        tail_we |-> rsp_valid && rsp_code == 3'd0); // R9
    AST_PEND_SIGNALS: assert property (@(posedge clk) disable iff (rst)
        set_pend |-> evt_req && tail_we); // R10
    AST_ERR_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == 3'd6 |-> !tail_we && !set_pend && !evt_req); // R11
endmodule

bind prq_writer prq_writer_sva #(.ADDR_W(ADDR_W)) u_prq_writer_sva (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mw_valid  (mw_valid),
    .mw_ready  (mw_ready),
    .mw_addr   (mw_addr),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .fault     (fault),
    .tail_we   (tail_we),
    .set_ovf   (set_ovf),
    .set_pend  (set_pend),
    .evt_req   (evt_req)
);

// File: tb/test_prq_writer.sv
module test_prq_writer;
    localparam int ADDR_W = 64;
    localparam int OFF_W  = 19;
    localparam int NV     = 12;

    typedef struct packed {
        logic        pv;
        logic        ex;
        logic        rd;
        logic        wr;
        logic        pe;
        logic        ovf;
        logic        pend;
        logic        err;
        logic [2:0]  sz;
        logic [18:0] head;
        logic [18:0] tail;
        logic [2:0]  code;
    } vec_t;

    // pv ex rd wr pe ovf pend err sz head tail code
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,19'h00000,19'h00020,3'd1},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,19'h00000,19'h00020,3'd2},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,19'h00000,19'h00020,3'd1},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,19'h00000,19'h00020,3'd3},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd0,19'h00000,19'h00FE0,3'd4},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,3'd0,19'h00000,19'h00FE0,3'd5},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,19'h00060,19'h00020,3'd0},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,3'd0,19'h00040,19'h00FE0,3'd0},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,3'd1,19'h00000,19'h00FE0,3'd0},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd7,19'h00100,19'h7FFE0,3'd0},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,3'd2,19'h00000,19'h00400,3'd6},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd3,19'h00000,19'h01000,3'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [15:0] req_rid = '0;
    logic req_pasid_vld = 1'b0;
    logic [19:0] req_pasid = '0;
    logic req_priv = 1'b0, req_exec = 1'b0, req_rd = 1'b0, req_wr = 1'b0, req_last = 1'b0;
    logic [8:0] req_grp = '0;
    logic [51:0] req_page = '0;
    logic ctx_pr_en = 1'b0;
    logic [ADDR_W-13:0] q_base = 52'h0_0001_2345_6;
    logic [2:0] q_size = '0;
    logic [OFF_W-1:0] q_head = '0, q_tail = '0;
    logic tail_we;
    logic [OFF_W-1:0] tail_nxt;
    logic mw_valid;
    logic mw_ready = 1'b1;
    logic [ADDR_W-1:0] mw_addr;
    logic [127:0] mw_data;
    logic mw_resp_valid = 1'b0, mw_resp_err = 1'b0;
    logic st_ovf = 1'b0, st_pend = 1'b0;
    logic set_ovf, set_pend, evt_req;
    logic [1:0] evt_old;
    logic rsp_valid;
    logic [2:0] rsp_code;
    logic fault;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    prq_writer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_prq_writer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_rid(req_rid), .req_pasid_vld(req_pasid_vld), .req_pasid(req_pasid),
        .req_priv(req_priv), .req_exec(req_exec), .req_rd(req_rd), .req_wr(req_wr),
        .req_last(req_last), .req_grp(req_grp), .req_page(req_page),
        .ctx_pr_en(ctx_pr_en), .q_base(q_base), .q_size(q_size), .q_head(q_head),
        .q_tail(q_tail), .tail_we(tail_we), .tail_nxt(tail_nxt),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .mw_resp_valid(mw_resp_valid), .mw_resp_err(mw_resp_err),
        .st_ovf(st_ovf), .st_pend(st_pend), .set_ovf(set_ovf), .set_pend(set_pend),
        .evt_req(evt_req), .evt_old(evt_old), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .fault(fault)
    );

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [127:0] build_desc(input int i, input logic rd, input logic wr);
        logic [63:0] lo, hi;
        lo = 64'h0;
        hi = 64'h0;
        lo[7:0]   = 8'h01;
        lo[9]     = 1'b1;
        lo[31:16] = 16'h4100 + 16'(i);
        lo[51:32] = 20'hC0DE0 + 20'(i);
        lo[53]    = i[0];
        hi[0]     = rd;
        hi[1]     = wr;
        hi[2]     = i[1];
        hi[11:3]  = 9'h100 + 9'(i);
        hi[63:12] = 52'h00ABC_DEF00 + 52'(i);
        return {hi, lo};
    endfunction

    function automatic logic [18:0] model_tail(input logic [18:0] t, input logic [2:0] sz);
        longint span;
        span = longint'(1) << (int'(sz) + 12);
        return 19'((longint'(t) + 32) % span);
    endfunction

    function automatic string code_tag(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input int i, input vec_t v);
        req_rid       = 16'h4100 + 16'(i);
        req_pasid_vld = v.pv;
        req_pasid     = 20'hC0DE0 + 20'(i);
        req_priv      = i[0];
        req_exec      = v.ex;
        req_rd        = v.rd;
        req_wr        = v.wr;
        req_last      = i[1];
        req_grp       = 9'h100 + 9'(i);
        req_page      = 52'h00ABC_DEF00 + 52'(i);
        ctx_pr_en     = v.pe;
        st_ovf        = v.ovf;
        st_pend       = v.pend;
        q_size        = v.sz;
        q_head        = v.head;
        q_tail        = v.tail;
    endtask

    task automatic run_vec(input int i, input vec_t v);
        logic writes;
        logic exp_evt;
        logic [1:0] exp_old;
        string tag;
        tag    = code_tag(v.code);
        writes = (v.code == 3'd0) || (v.code == 3'd6);
        @(negedge clk);
        apply(i, v);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(writes ? "R7" : tag, "mw_valid", 128'(mw_valid), 128'(writes));
        if (writes) begin
            check("R12", "req_ready during write", 128'(req_ready), 128'(0));
            check("R7", "mw_addr", 128'(mw_addr), 128'({q_base, 12'h000} + 64'(v.tail)));
            check("R8", "mw_data", mw_data, build_desc(i, v.rd, v.wr));
            @(posedge clk);
            @(negedge clk);
            mw_resp_valid = 1'b1;
            mw_resp_err   = v.err;
            @(posedge clk);
            @(negedge clk);
            mw_resp_valid = 1'b0;
            mw_resp_err   = 1'b0;
        end
        check(tag, "rsp_valid", 128'(rsp_valid), 128'(1));
        check(tag, "rsp_code", 128'(rsp_code), 128'(v.code));
        check("R4", "fault", 128'(fault), 128'(v.code == 3'd3));
        check("R6", "set_ovf", 128'(set_ovf), 128'(v.code == 3'd5));
        check("R9", "tail_we", 128'(tail_we), 128'(v.code == 3'd0));
        if (v.code == 3'd0)
            check("R9", "tail_nxt", 128'(tail_nxt), 128'(model_tail(v.tail, v.sz)));
        check("R10", "set_pend", 128'(set_pend), 128'(v.code == 3'd0 && !v.pend));
        exp_evt = (v.code == 3'd5) || (v.code == 3'd0 && !v.pend);
        exp_old = {v.pend, v.ovf};
        check(v.code == 3'd5 ? "R6" : "R10", "evt_req", 128'(evt_req), 128'(exp_evt));
        if (exp_evt)
            check(v.code == 3'd5 ? "R6" : "R10", "evt_old", 128'(evt_old), 128'(exp_old));
        @(negedge clk);
        check("R12", "req_ready after result", 128'(req_ready), 128'(1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "req_ready", 128'(req_ready), 128'(1));
        check("R1", "mw_valid", 128'(mw_valid), 128'(0));
        check("R1", "strobes",
              128'({rsp_valid, tail_we, set_ovf, set_pend, evt_req, fault}), 128'(0));

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R12: write held while memory stalls
        @(negedge clk);
        apply(20, VECS[6]);
        q_tail    = 19'h00200;
        q_head    = 19'h00000;
        mw_ready  = 1'b0;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R12", "mw_valid held", 128'(mw_valid), 128'(1));
            check("R12", "addr held", 128'(mw_addr), 128'({q_base, 12'h000} + 64'h200));
            check("R12", "req_ready low", 128'(req_ready), 128'(0));
            @(negedge clk);
        end
        mw_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mw_resp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mw_resp_valid = 1'b0;
        check("R9", "rsp after stall", 128'(rsp_code), 128'(0));
        check("R9", "tail after stall", 128'(tail_nxt), 128'(19'h00220));

        // R1: reset during a pending write
        @(negedge clk);
        apply(21, VECS[6]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "mw_valid after reset", 128'(mw_valid), 128'(0));
        check("R1", "req_ready after reset", 128'(req_ready), 128'(1));

        summary();
    end
endmodule